// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block sits inside one channel of a DMA controller and turns an in-memory chain of fixed-size scatter-gather entries into a stream of transfer commands. A pulse on `start` with a 32-bit list pointer starts a walk. For each entry the block reads two 32-bit words through a read port: a header word first, then a buffer-address word. It checks the header flags, then hands the buffer address, byte count and the channel's row width to a data mover over a valid/ready handshake. It waits for the mover's `xfer_done` before it moves on.

Entries are 8 bytes long and packed back to back; there is no link field, so the next entry is always 8 bytes further on. The walk ends after the entry flagged as final and gives a one-cycle `done_pulse`. A malformed entry ends it early with `err` set and no completion pulse. `stop` aborts the walk at any point.

The controller has six states. IDLE waits for `start` and goes to HDR_FETCH. HDR_FETCH goes to ADR_FETCH on a good header and back to IDLE on a bad one. ADR_FETCH goes to ISSUE when the entry carries data and to ADVANCE when it is skipped. ISSUE goes to WAIT_DONE on `cmd_ready`. WAIT_DONE goes to ADVANCE on `xfer_done`. ADVANCE goes to IDLE after the final entry and otherwise back to HDR_FETCH. `stop` takes any state to IDLE.

Top module: `sg_list_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req_valid`, `cmd_valid`, `done_pulse` and `err` are all 0.
- R2: A walk started at pointer P reads the header of entry k at P+8k and then its address word at P+8k+4. Reads happen in that order, and `rd_req_valid` is held with a steady address until `rd_resp_valid`.
- R3: Header word layout: bit 0 is valid, bit 1 is final, bit 5 is data-carrying, bits 31:16 are the byte count, and bits 15:8 are ignored. The address word is the buffer address. Each command carries that address, that count, and the `row_bytes` value captured at `start`.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_row` hold steady.
- R5: After a command is accepted, the block issues no read until `xfer_done` has been seen.
- R6: A valid entry with a zero byte count, or with bit 5 clear, gives no command. The walk goes on to the next entry, or ends if that entry is final.
- R7: After the final entry is handled, `done_pulse` is high for exactly one cycle with `busy` low. This happens once per successful walk.
- R8: A header with the valid bit clear ends the walk: no command for it, `err` set to 1, `busy` low, no `done_pulse`.
- R9: A header whose byte count is not a multiple of 4 ends the walk the same way as R8, with no command for it.
- R10: `stop` makes `busy` low by the next cycle with no `done_pulse`. No further reads or commands are issued.
- R11: `start` while busy is ignored. The walk in progress keeps its pointer.
- R12: `err` stays set until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | begin a walk at `list_ptr` |
| stop | input | 1 | abort the walk |
| list_ptr | input | 32 | byte address of the first entry |
| row_bytes | input | 16 | row width passed with every command |
| rd_req_valid | output | 1 | read request held until response |
| rd_req_addr | output | 32 | byte address of the word to read |
| rd_resp_valid | input | 1 | read data valid |
| rd_resp_data | input | 32 | read data |
| cmd_valid | output | 1 | transfer command valid |
| cmd_ready | input | 1 | mover accepts the command |
| cmd_addr | output | 32 | buffer address |
| cmd_len | output | 16 | byte count |
| cmd_row | output | 16 | row width |
| xfer_done | input | 1 | mover finished the accepted command |
| busy | output | 1 | walk in progress |
| done_pulse | output | 1 | one-cycle completion |
| err | output | 1 | last walk ended on a malformed entry |

## Verification
The bench runs eight list shapes against three memory and mover latencies. The shapes include a zero-length entry in the middle, a zero-length final entry, a non-data entry, the largest aligned count, an invalid second entry and a misaligned first entry. A block that skipped badly would emit an empty command or stall, and one that checked alignment late would issue a command for the bad entry. Every read address is logged, so a wrong step between entries or a wrong word order shows up as an address mismatch. Separate runs pulse `stop` during a transfer and during a fetch, where a faulty block would keep walking or still give `done_pulse`. They also pulse `start` again mid-walk, where a faulty block would reload its pointer.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_FETCH,
        ST_ADR_FETCH,
        ST_ISSUE,
        ST_WAIT_DONE,
        ST_ADVANCE
    } walk_state_t;

    // header flag bit positions (behavioural: the descriptor producer encodes these)
    localparam int FLAG_VALID_BIT = 0;
    localparam int FLAG_FINAL_BIT = 1;
    localparam int FLAG_DATA_BIT  = 5;
    localparam int LEN_LSB        = 16;
endpackage

// File: rtl/sg_hdr_check.sv
module sg_hdr_check #(
    parameter int LEN_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic             flag_valid,
    input  logic             flag_final,
    input  logic             flag_data,
    input  logic [LEN_W-1:0] len_in,
    output logic             hdr_ok,
    output logic             hdr_final,
    output logic             hdr_moves
);
    logic aligned;

    always_comb begin
        aligned   = (len_in[ALIGN_BITS-1:0] == '0);
        hdr_ok    = flag_valid && aligned;
        hdr_final = flag_final;
        hdr_moves = flag_data && (len_in != '0);
    end
endmodule

// File: rtl/sg_entry_ptr.sv
module sg_entry_ptr #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              second_word,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int ENTRY_BYTES = 2 * WORD_BYTES;

    logic [ADDR_W-1:0] entry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (load) begin
            entry_q <= load_addr;
        end else if (step) begin
            entry_q <= entry_q + ADDR_W'(ENTRY_BYTES);
        end
    end

    always_comb begin
        word_addr = second_word ? entry_q + ADDR_W'(WORD_BYTES) : entry_q;
    end
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 16,
    parameter int ROW_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] list_ptr,
    input  logic [ROW_W-1:0]  row_bytes,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_resp_valid,
    input  logic [DATA_W-1:0] rd_resp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [ROW_W-1:0]  cmd_row,
    input  logic              xfer_done,
    output logic              busy,
    output logic              done_pulse,
    output logic              err
);
    import sg_walk_pkg::*;

    localparam int WORD_BYTES = DATA_W / 8;

    walk_state_t state_q, state_d;

    logic [LEN_W-1:0]  len_q;
    logic              final_q;
    logic              moves_q;
    logic [ADDR_W-1:0] buf_q;
    logic [ROW_W-1:0]  row_q;
    logic              err_q;
    logic              done_q;

    logic              hdr_ok, hdr_final, hdr_moves;
    logic              launch, step_entry, hdr_seen, adr_seen;

    sg_hdr_check #(
        .LEN_W      (LEN_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_hdr (
        .flag_valid (rd_resp_data[FLAG_VALID_BIT]),
        .flag_final (rd_resp_data[FLAG_FINAL_BIT]),
        .flag_data  (rd_resp_data[FLAG_DATA_BIT]),
        .len_in     (rd_resp_data[LEN_LSB +: LEN_W]),
        .hdr_ok     (hdr_ok),
        .hdr_final  (hdr_final),
        .hdr_moves  (hdr_moves)
    );

    sg_entry_ptr #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (launch),
        .load_addr   (list_ptr),
        .step        (step_entry),
        .second_word (state_q == ST_ADR_FETCH),
        .word_addr   (rd_req_addr)
    );

    always_comb begin
        launch     = (state_q == ST_IDLE) && start && !stop;
        step_entry = (state_q == ST_ADVANCE) && !final_q && !stop;
        hdr_seen   = (state_q == ST_HDR_FETCH) && rd_resp_valid && !stop;
        adr_seen   = (state_q == ST_ADR_FETCH) && rd_resp_valid && !stop;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (start) state_d = ST_HDR_FETCH;
                ST_HDR_FETCH: if (rd_resp_valid) state_d = hdr_ok ? ST_ADR_FETCH : ST_IDLE;
                ST_ADR_FETCH: if (rd_resp_valid) state_d = moves_q ? ST_ISSUE : ST_ADVANCE;
                ST_ISSUE:     if (cmd_ready) state_d = ST_WAIT_DONE;
                ST_WAIT_DONE: if (xfer_done) state_d = ST_ADVANCE;
                ST_ADVANCE:   state_d = final_q ? ST_IDLE : ST_HDR_FETCH;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured entry fields and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            final_q <= 1'b0;
            moves_q <= 1'b0;
            buf_q   <= '0;
            row_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_ADVANCE) && final_q && !stop;
            if (launch) begin
                row_q <= row_bytes;
                err_q <= 1'b0;
            end
            if (hdr_seen) begin
                len_q   <= rd_resp_data[LEN_LSB +: LEN_W];
                final_q <= hdr_final;
                moves_q <= hdr_moves;
                if (!hdr_ok) begin
                    err_q <= 1'b1;
                end
            end
            if (adr_seen) begin
                buf_q <= rd_resp_data[ADDR_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        rd_req_valid = (state_q == ST_HDR_FETCH) || (state_q == ST_ADR_FETCH);
        cmd_valid    = (state_q == ST_ISSUE);
        cmd_addr     = buf_q;
        cmd_len      = len_q;
        cmd_row      = row_q;
        done_pulse   = done_q;
        err          = err_q;
    end
endmodule

// File: rtl/sg_list_walker_chk.sv
module sg_list_walker_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int ROW_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              rd_req_valid,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              rd_resp_valid,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [ROW_W-1:0]  cmd_row,
    input logic              busy,
    input logic              done_pulse,
    input logic              err
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_resp_valid && !stop |=> rd_req_valid && $stable(rd_req_addr)); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !stop |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_row)); // R4

    AST_NO_RD_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && cmd_valid)); // R5

    AST_CMD_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) && (cmd_len[ALIGN_BITS-1:0] == '0)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R7

    AST_DONE_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy && !err); // R7

    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy && !done_pulse && !rd_req_valid && !cmd_valid); // R10
endmodule

bind sg_list_walker sg_list_walker_chk #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .ROW_W      (ROW_W),
    .ALIGN_BITS (ALIGN_BITS)
) u_chk (.*);

// File: tb/sg_list_walker_test.sv
module sg_list_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [31:0] list_ptr = '0;
    logic [15:0] row_bytes = '0;
    logic        rd_req_valid;
    logic [31:0] rd_req_addr;
    logic        rd_resp_valid = 1'b0;
    logic [31:0] rd_resp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_len;
    logic [15:0] cmd_row;
    logic        xfer_done = 1'b0;
    logic        busy, done_pulse, err;

    always #4 clk = ~clk;  // 125 MHz

    sg_list_walker uut (.*);

    int n_chk = 0, n_bad = 0, cycles = 0, lat_cfg = 1;
    logic [31:0] mem [0:63];

    // descriptor image kept by the bench
    int          d_n;
    logic [7:0]  d_flags [0:7];
    logic [15:0] d_len   [0:7];
    logic [31:0] d_addr  [0:7];

    // observation logs
    int n_rd, n_cmd, n_done, viol;
    bit inflight;
    logic [31:0] rd_log   [0:31];
    logic [31:0] cadr_log [0:15];
    logic [15:0] clen_log [0:15];
    logic [15:0] crow_log [0:15];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // read port model: answers after lat_cfg cycles of a held request
    int rcnt = 0;
    always @(negedge clk) begin
        rd_resp_valid <= 1'b0;
        if (rd_req_valid) begin
            rcnt = rcnt + 1;
            if (rcnt >= lat_cfg) begin
                rd_resp_valid <= 1'b1;
                rd_resp_data  <= mem[rd_req_addr[7:2]];
                rcnt = 0;
            end
        end else begin
            rcnt = 0;
        end
    end

    // data mover model
    int mstate = 0, mcnt = 0;
    always @(negedge clk) begin
        cmd_ready <= 1'b0;
        xfer_done <= 1'b0;
        if (mstate == 0 && cmd_valid) begin
            mcnt = mcnt + 1;
            if (mcnt >= lat_cfg) begin
                cmd_ready <= 1'b1;
                mstate = 1;
                mcnt = 0;
            end
        end else if (mstate == 1) begin
            mcnt = mcnt + 1;
            if (mcnt > lat_cfg) begin
                xfer_done <= 1'b1;
                mstate = 0;
                mcnt = 0;
            end
        end
    end

    // monitor
    always @(posedge clk) begin
        cycles++;
        if (rd_req_valid && rd_resp_valid) begin
            if (n_rd < 32) rd_log[n_rd] = rd_req_addr;
            n_rd++;
        end
        if (inflight && rd_req_valid) viol++;
        if (cmd_valid && cmd_ready) begin
            if (n_cmd < 16) begin
                cadr_log[n_cmd] = cmd_addr;
                clen_log[n_cmd] = cmd_len;
                crow_log[n_cmd] = cmd_row;
            end
            n_cmd++;
            inflight = 1'b1;
        end
        if (xfer_done) inflight = 1'b0;
        if (done_pulse) n_done++;
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    task automatic put(input int base, input int k, input logic [7:0] f, input logic [15:0] len,
                       input logic [31:0] a);
        d_flags[k] = f;
        d_len[k]   = len;
        d_addr[k]  = a;
        mem[(base >> 2) + 2 * k]     = {len, 8'hA5, f};  // byte 1 nonzero: must be ignored (R3)
        mem[(base >> 2) + 2 * k + 1] = a;
    endtask

    function automatic logic [31:0] ea(input int p, input int lat, input int k);
        return 32'h8000_0000 + (p << 12) + (k << 6) + (lat << 2);
    endfunction

    task automatic build(input int p, input int lat, input int base);
        case (p)
            0: begin d_n = 1; put(base, 0, 8'h23, 16'd4, ea(p, lat, 0)); end
            1: begin d_n = 3; put(base, 0, 8'h21, 16'd8, ea(p, lat, 0));
                     put(base, 1, 8'h21, 16'd12, ea(p, lat, 1));
                     put(base, 2, 8'h23, 16'd16, ea(p, lat, 2)); end
            2: begin d_n = 4; put(base, 0, 8'h21, 16'd4, ea(p, lat, 0));
                     put(base, 1, 8'h21, 16'd0, ea(p, lat, 1));
                     put(base, 2, 8'h21, 16'd20, ea(p, lat, 2));
                     put(base, 3, 8'h23, 16'd8, ea(p, lat, 3)); end
            3: begin d_n = 3; put(base, 0, 8'h21, 16'd24, ea(p, lat, 0));
                     put(base, 1, 8'h01, 16'd32, ea(p, lat, 1));
                     put(base, 2, 8'h23, 16'd28, ea(p, lat, 2)); end
            4: begin d_n = 2; put(base, 0, 8'h21, 16'd4, ea(p, lat, 0));
                     put(base, 1, 8'h22, 16'd8, ea(p, lat, 1)); end
            5: begin d_n = 2; put(base, 0, 8'h21, 16'd6, ea(p, lat, 0));
                     put(base, 1, 8'h23, 16'd8, ea(p, lat, 1)); end
            6: begin d_n = 2; put(base, 0, 8'h21, 16'd40, ea(p, lat, 0));
                     put(base, 1, 8'h23, 16'd0, ea(p, lat, 1)); end
            default: begin d_n = 1; put(base, 0, 8'h23, 16'hFFFC, ea(p, lat, 0)); end
        endcase
    endtask

    task automatic clear_logs();
        n_rd = 0; n_cmd = 0; n_done = 0; viol = 0; inflight = 1'b0;
    endtask

    task automatic launch(input int base, input logic [15:0] row);
        list_ptr  = base;
        row_bytes = row;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        row_bytes = ~row;  // captured at start only (R3)
    endtask

    task automatic run(input int p, input int lat, input bit poke);
        int base = p * 32;
        logic [15:0] row = 16'h0100 + 16'(p * 16 + lat);
        int e_err = 0, e_rd = 0, e_cmd = 0, t = 0;
        logic [31:0] x_rd [0:31];
        logic [31:0] x_adr [0:15];
        logic [15:0] x_len [0:15];
        lat_cfg = lat;
        build(p, lat, base);
        clear_logs();
        launch(base, row);
        if (poke) begin
            repeat (2) @(negedge clk);
            list_ptr = ((p + 3) % 8) * 32;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (busy && t < 4000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        // independent walk of the list
        for (int k = 0; k < d_n; k++) begin
            x_rd[e_rd++] = base + 8 * k;
            if (!d_flags[k][0] || (d_len[k] % 4 != 0)) begin e_err = 1; break; end
            x_rd[e_rd++] = base + 8 * k + 4;
            if (d_flags[k][5] && d_len[k] != 0) begin
                x_adr[e_cmd] = d_addr[k];
                x_len[e_cmd] = d_len[k];
                e_cmd++;
            end
            if (d_flags[k][1]) break;
        end
        if (p == 4) chk("R8 err after invalid header", {31'd0, err}, 1);
        else if (p == 5) chk("R9 err after misaligned length", {31'd0, err}, 1);
        else chk("R12 err clear on good walk", {31'd0, err}, 0);
        chk("R7 done pulse count", n_done, e_err ? 0 : 1);
        chk("R6 command count", n_cmd, e_cmd);
        chk("R2 read count", n_rd, e_rd);
        chk("R5 read during transfer", viol, 0);
        for (int i = 0; i < e_rd && i < n_rd; i++)
            chk(poke ? "R11 read address after ignored start" : "R2 read address", rd_log[i], x_rd[i]);
        for (int i = 0; i < e_cmd && i < n_cmd; i++) begin
            chk("R3 command address", cadr_log[i], x_adr[i]);
            chk("R3 command length", {16'd0, clen_log[i]}, {16'd0, x_len[i]});
            chk("R3 command row", {16'd0, crow_log[i]}, {16'd0, row});
        end
    endtask

    task automatic stop_run(input int wait_cmds);
        int t = 0;
        lat_cfg = 2;
        build(1, 2, 32);
        clear_logs();
        launch(32, 16'h0042);
        while (n_cmd < wait_cmds && t < 200) begin @(negedge clk); t++; end
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        chk("R10 busy low after stop", {31'd0, busy}, 0);
        repeat (30) @(negedge clk);
        chk("R10 no commands after stop", n_cmd, wait_cmds);
        chk("R10 no done after stop", n_done, 0);
        chk("R10 still idle", {31'd0, busy}, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", {31'd0, busy}, 0);
        chk("R1 read request at reset", {31'd0, rd_req_valid}, 0);
        chk("R1 command at reset", {31'd0, cmd_valid}, 0);
        chk("R1 done at reset", {31'd0, done_pulse}, 0);
        chk("R1 err at reset", {31'd0, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int lat = 1; lat <= 3; lat++)
            for (int p = 0; p < 8; p++)
                run(p, lat, 1'b0);
        run(1, 2, 1'b1);
        run(2, 1, 1'b1);
        stop_run(1);
        stop_run(0);
        run(0, 1, 1'b0);
        finish_run();
    end
endmodule